// File: doc/BRIEF.md
# Dual Current Fault Detector

This block watches two redundant current measurements of one load, the phase-conductor current and the return (neutral) current, together with a zero-crossing indication from the voltage channel. For every magnitude sample it decides which current channel feeds the billing path and forwards that channel's magnitude. It also raises a fault when the two currents disagree by more than one sixteenth of the larger one (6.25%), and when the voltage has gone silent.

The magnitudes arrive already rectified or averaged, one pair per strobe. A channel swap only happens after the other channel has been the larger one for a set number of consecutive samples, which stops the select from chattering when the currents are nearly equal. A mismatch fault is raised at once and cleared with the same hysteresis.

The voltage is judged absent when no zero-crossing pulse arrives within a set number of clock cycles. The block then reports a missing-neutral condition and drives the fault output high. Billing carries on from the current channels alone. Power multiplication, filtering and magnitude estimation are done elsewhere.

Top module: `curr_fault_mon`

## Requirements
- R1: After reset, sel_o=0, bill_mag_o=0, fault_o=0 and no_neutral_o=0.
- R2: On each strobe, bill_mag_o takes the magnitude of the channel that sel_o selects after that strobe (sel_o 0 = phase, 1 = neutral). It does so whether or not a fault is present.
- R3: The mismatch fault sets on the strobe where |phase−neutral| > max(phase,neutral)>>4. fault_o is then high from the next clock edge. A difference exactly equal to max>>4 does not fault.
- R4: sel_o moves to the other channel only after PERSIST consecutive strobes on which that channel is the larger. Neutral counts as larger only when strictly greater, so ties favour phase. A strobe that favours the current channel restarts the count.
- R5: A mismatch fault clears only after PERSIST consecutive strobes with no mismatch.
- R6: The voltage counts as absent once V_TIMEOUT clock cycles pass without a zc_i pulse. On the next strobe, no_neutral_o and fault_o go high.
- R7: While no_neutral_o is high, bill_mag_o still updates on every strobe from the selected current channel.
- R8: no_neutral_o clears only after PERSIST consecutive strobes with voltage present.
- R9: sel_o and the fault states change only on clock edges where smp_valid_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample strobe, one cycle per magnitude pair |
| phase_mag_i | input | MAG_W | Phase current magnitude |
| neut_mag_i | input | MAG_W | Neutral current magnitude |
| zc_i | input | 1 | Voltage zero-crossing pulse |
| sel_o | output | 1 | Billing channel: 0 phase, 1 neutral |
| bill_mag_o | output | MAG_W | Magnitude of the billed channel |
| fault_o | output | 1 | Mismatch fault or missing neutral |
| no_neutral_o | output | 1 | Missing-neutral status |

## Verification
The assertions check several rules on every cycle. The filtered states stay stable between strobes. A mismatch strobe always sets the fault. The billed magnitude always matches the selected channel's last sample. A zero-crossing always clears the voltage-absent flag, and missing neutral only rises while the voltage is absent. Other behaviour can only be shown by the bench's scenarios: the exact 6.25% boundary, the restart of the persistence count by one contrary sample, the hysteresis on clearing, and billing that continues through a missing-neutral episode.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
  localparam int unsigned FAULT_SHIFT = 4;  // 1/16 = 6.25 %
  typedef enum logic {CH_PHASE = 1'b0, CH_NEUTRAL = 1'b1} ch_e;
endpackage

// File: rtl/cfm_compare.sv
module cfm_compare #(
  parameter int unsigned MAG_W = 16
) (
  input  logic [MAG_W-1:0] phase_i,
  input  logic [MAG_W-1:0] neut_i,
  output logic             neut_gt_o,
  output logic             mismatch_o
);
  import cfm_pkg::*;
  logic [MAG_W-1:0] diff, larger;

  always_comb begin
    neut_gt_o = neut_i > phase_i;
    if (neut_gt_o) begin
      diff   = neut_i - phase_i;
      larger = neut_i;
    end else begin
      diff   = phase_i - neut_i;
      larger = phase_i;
    end
    mismatch_o = diff > (larger >> FAULT_SHIFT);
  end
endmodule

// File: rtl/cfm_persist.sv
// Holds a state bit; flips it after N consecutive enabled samples disagree.
module cfm_persist #(
  parameter int unsigned SET_N = 1,
  parameter int unsigned CLR_N = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic raw_i,
  output logic state_o
);
  localparam int unsigned MAXN = (SET_N > CLR_N) ? SET_N : CLR_N;
  localparam int unsigned CW   = (MAXN < 2) ? 1 : $clog2(MAXN + 1);
  localparam logic [CW-1:0] SET_M1 = CW'(SET_N - 1);
  localparam logic [CW-1:0] CLR_M1 = CW'(CLR_N - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] need_m1;

  assign need_m1 = state_o ? CLR_M1 : SET_M1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= 1'b0;
      cnt_q   <= '0;
    end else if (en_i) begin
      if (raw_i == state_o) begin
        cnt_q <= '0;
      end else if (cnt_q == need_m1) begin
        state_o <= raw_i;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assert_stable_between_strobes_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(state_o));
  assert_count_bounded_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(MAXN));
endmodule

// File: rtl/cfm_vmon.sv
module cfm_vmon #(
  parameter int unsigned V_TIMEOUT = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic zc_i,
  output logic absent_o
);
  localparam int unsigned TW = $clog2(V_TIMEOUT + 1);
  localparam logic [TW-1:0] LIMIT = TW'(V_TIMEOUT);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (zc_i)             cnt_q <= '0;
    else if (cnt_q != LIMIT)   cnt_q <= cnt_q + 1'b1;
  end

  assign absent_o = (cnt_q == LIMIT);

  assert_zc_clears_absent_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zc_i |=> !absent_o);
endmodule

// File: rtl/curr_fault_mon.sv
module curr_fault_mon #(
  parameter int unsigned MAG_W     = 16,
  parameter int unsigned PERSIST   = 4,
  parameter int unsigned V_TIMEOUT = 1024
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_valid_i,
  input  logic [MAG_W-1:0] phase_mag_i,
  input  logic [MAG_W-1:0] neut_mag_i,
  input  logic             zc_i,
  output logic             sel_o,
  output logic [MAG_W-1:0] bill_mag_o,
  output logic             fault_o,
  output logic             no_neutral_o
);
  import cfm_pkg::*;

  logic neut_gt, mismatch, v_absent, mm_fault;
  logic [MAG_W-1:0] phase_q, neut_q;
  ch_e  sel_ch;

  cfm_compare #(.MAG_W(MAG_W)) u_cmp (
    .phase_i(phase_mag_i), .neut_i(neut_mag_i),
    .neut_gt_o(neut_gt), .mismatch_o(mismatch)
  );

  cfm_vmon #(.V_TIMEOUT(V_TIMEOUT)) u_vmon (
    .clk_i(clk_i), .rst_ni(rst_ni), .zc_i(zc_i), .absent_o(v_absent)
  );

  cfm_persist #(.SET_N(PERSIST), .CLR_N(PERSIST)) u_sel (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(smp_valid_i),
    .raw_i(neut_gt), .state_o(sel_o)
  );

  // faults set on first bad sample, clear with hysteresis
  cfm_persist #(.SET_N(1), .CLR_N(PERSIST)) u_mm (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(smp_valid_i),
    .raw_i(mismatch), .state_o(mm_fault)
  );

  cfm_persist #(.SET_N(1), .CLR_N(PERSIST)) u_nn (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(smp_valid_i),
    .raw_i(v_absent), .state_o(no_neutral_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      neut_q  <= '0;
    end else if (smp_valid_i) begin
      phase_q <= phase_mag_i;
      neut_q  <= neut_mag_i;
    end
  end

  assign sel_ch     = ch_e'(sel_o);
  assign bill_mag_o = (sel_ch == CH_NEUTRAL) ? neut_q : phase_q;
  assign fault_o    = mm_fault | no_neutral_o;

  assert_mismatch_sets_fault_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i && mismatch |=> fault_o);
  assert_bill_tracks_select_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i |=> bill_mag_o == (sel_o ? $past(neut_mag_i) : $past(phase_mag_i)));
  assert_nn_rise_needs_absent_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(no_neutral_o) |-> $past(v_absent));
endmodule

// File: tb/sim_curr_fault_mon.sv
`timescale 1ns/1ps
module sim_curr_fault_mon;
  localparam int unsigned MAG_W = 16;
  localparam int unsigned PERSIST = 3;
  localparam int unsigned V_TIMEOUT = 40;

  logic clk = 1'b0, rst_n = 1'b0, valid = 1'b0, zc = 1'b0, zc_en = 1'b1;
  logic [MAG_W-1:0] phase = '0, neut = '0;
  logic sel, fault, nn;
  logic [MAG_W-1:0] bill;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  curr_fault_mon #(.MAG_W(MAG_W), .PERSIST(PERSIST), .V_TIMEOUT(V_TIMEOUT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(valid),
    .phase_mag_i(phase), .neut_mag_i(neut), .zc_i(zc),
    .sel_o(sel), .bill_mag_o(bill), .fault_o(fault), .no_neutral_o(nn)
  );

  initial forever begin
    repeat (10) @(negedge clk);
    if (zc_en) zc = 1'b1;
    @(negedge clk);
    zc = 1'b0;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; valid = 1'b0; zc_en = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic smp(int p, int n);
    phase = MAG_W'(p); neut = MAG_W'(n); valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 sel", sel, 0); chk("R1 bill", bill, 0);
    chk("R1 fault", fault, 0); chk("R1 nn", nn, 0);
  endtask

  task automatic t_select();
    do_reset();
    smp(1000, 990);
    chk("R2 bill phase", bill, 1000); chk("R2 sel", sel, 0); chk("R3 no fault", fault, 0);
    smp(1000, 1000);
    chk("R4 tie keeps phase", sel, 0);
    smp(1000, 1010); smp(1000, 1010);
    smp(1010, 1000);               // restarts count
    smp(1000, 1010); smp(1000, 1010);
    chk("R4 restart holds", sel, 0); chk("R2 bill held phase", bill, 1000);
    smp(1000, 1010);
    chk("R4 switch after persist", sel, 1); chk("R2 bill neutral", bill, 1010);
    repeat (5) @(negedge clk);
    chk("R9 stable w/o strobe", sel, 1);
  endtask

  task automatic t_fault();
    do_reset();
    smp(1600, 1500);
    chk("R3 boundary no fault", fault, 0);
    smp(1600, 1499);
    chk("R3 fault set", fault, 1);
    smp(1000, 2000); smp(1000, 2000);
    smp(1000, 2000);
    chk("R2 bill larger in fault", bill, 2000); chk("R2 sel in fault", sel, 1);
    chk("R5 fault held", fault, 1);
    smp(2000, 2000); smp(2000, 2000);
    chk("R5 not yet clear", fault, 1);
    repeat (4) @(negedge clk);
    chk("R9 fault no strobe", fault, 1);
    smp(2000, 2000);
    chk("R5 cleared", fault, 0);
  endtask

  task automatic t_neutral();
    do_reset();
    zc_en = 1'b0;
    repeat (30) @(negedge clk);
    smp(500, 490);
    chk("R6 before timeout", nn, 0);
    repeat (30) @(negedge clk);
    chk("R9 nn waits for strobe", nn, 0);
    smp(500, 490);
    chk("R6 nn set", nn, 1); chk("R6 fault high", fault, 1);
    smp(700, 690);
    chk("R7 billing continues", bill, 700);
    zc_en = 1'b1;
    repeat (12) @(negedge clk);
    smp(700, 690); smp(700, 690);
    chk("R8 nn held", nn, 1);
    smp(800, 790);
    chk("R8 nn cleared", nn, 0); chk("R8 fault cleared", fault, 0);
    chk("R7 bill", bill, 800);
  endtask

  initial begin
    t_reset();
    t_select();
    t_fault();
    t_neutral();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule